// File: doc/BRIEF.md
# Holdover Frequency Word Store

This block keeps a short history of a digital PLL's frequency control word. Holdover can then reuse a value taken before any disturbance of the reference. While the loop is in normal operation and locked, the block counts periodic ticks from an external timebase. Each time a full update period has elapsed, it copies the current control word into one of two storage slots. Successive copies alternate between the two slots. A one-bit pointer records which slot holds the newer copy.

The output always presents the older of the two slots. On entry to holdover the word applied to the oscillator is therefore between one and two update periods old, which keeps out a sample taken just as the reference degraded. Captures stop while holdover is requested or lock is lost, so the presented word stays frozen until normal operation resumes. Until both slots have been filled once since reset, the output carries the nominal centre word and the valid flag is low.

The period length is a parameter counted in timebase ticks, for example 30 ticks of a 1 ms timebase for a 30 ms period. Simulation shortens it.

Top module: `holdover_word_store`

## Requirements
- R1: After synchronous active-low reset, `hold_valid` is 0 and `hold_word` equals the centre word (only the MSB set, value 2^(WORD_W-1)).
- R2: With capture enabled (`locked`=1 and `holdover_req`=0), a capture happens on the TICKS_PER_PERIOD-th `tick` counted since enable began or since the previous capture. Cycles without `tick` do not advance the count. The capture becomes visible at the outputs after that clock edge.
- R3: While `locked` is 0, no capture happens and the tick count restarts. After `locked` returns to 1, a full TICKS_PER_PERIOD ticks are needed before the next capture.
- R4: While `holdover_req` is 1, no capture happens, `hold_word` stays unchanged, and the tick count restarts as in R3.
- R5: Captures alternate between two slots, starting with slot 0 after reset. Once valid, `hold_word` equals the word stored by the second most recent capture (the older slot).
- R6: `hold_valid` rises only with the second capture after reset. Until then `hold_word` is the centre word.
- R7: `hold_word` changes only in the cycle that follows a capture.
- R8: Changes of `ctrl_word` on cycles that are not capture cycles have no effect on `hold_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctrl_word | input | WORD_W | Live frequency control word from the loop filter |
| locked | input | 1 | High when the loop is in normal operation and locked |
| holdover_req | input | 1 | High while holdover is in force |
| tick | input | 1 | One-cycle pulse from the timebase |
| hold_word | output | WORD_W | Older stored word, or the centre word before valid |
| hold_valid | output | 1 | Both slots have been written since reset |

## Verification
The hardest case is the slot ordering after several interruptions. The tick count must have restarted correctly after each loss of lock and each holdover, and the older slot must be the one presented. The stimulus spaces ticks irregularly and changes `ctrl_word` between ticks. It drops `locked` partway through a period, then holds holdover across more ticks than one period contains, then resumes. This drives the pointer through several wraps, so the presented word must have come from the capture before the most recent one, with no partial period leaking in.

// File: rtl/hfws_pkg.sv
// Shared types for the holdover word store.
// Assumes nothing beyond a single clock domain.
package hfws_pkg;
    typedef enum logic [1:0] {
        FILL_EMPTY = 2'd0,
        FILL_ONE   = 2'd1,
        FILL_BOTH  = 2'd2
    } fill_e;
endpackage

// File: rtl/hfws_period_div.sv
// Counts timebase ticks while capture is enabled and raises a one-cycle
// capture strobe on the tick that completes a period.
// Assumes tick is a single-cycle pulse; the count restarts whenever
// capture is disabled.
module hfws_period_div #(
    parameter int TICKS_PER_PERIOD = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_en,
    input  logic tick,
    output logic cap_stb
);
    localparam int CW = (TICKS_PER_PERIOD > 1) ? $clog2(TICKS_PER_PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_PERIOD - 1);

    logic [CW-1:0] cnt;
    logic          at_last;

    assign at_last = (cnt == LAST);
    assign cap_stb = cap_en && tick && at_last;

    // Tick counter: cleared when disabled, wraps on the period's final tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!cap_en)
            cnt <= '0;
        else if (tick)
            cnt <= at_last ? '0 : cnt + 1'b1;
    end

    // R3
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> (cnt == '0));

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
endmodule

// File: rtl/hfws_slot_bank.sv
// Two ping-pong slots for the control word with a newer-slot pointer and
// a fill tracker. Presents the older slot.
// Assumes wr_en pulses once per capture.
module hfws_slot_bank
    import hfws_pkg::*;
#(
    parameter int          WORD_W = 24,
    parameter logic [WORD_W-1:0] INIT_WORD = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    output logic [WORD_W-1:0] older_word,
    output logic              both_full
);
    logic [WORD_W-1:0] slot [2];
    logic              newer;
    fill_e             fill;

    // One register per slot; each is written only when it is the older one.
    for (genvar s = 0; s < 2; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot[s] <= INIT_WORD;
            else if (wr_en && (newer != 1'(s)))
                slot[s] <= wr_word;
        end
    end

    // Pointer to the newer slot; reset points at slot 1 so slot 0 fills first.
    always_ff @(posedge clk) begin
        if (!rst_n)
            newer <= 1'b1;
        else if (wr_en)
            newer <= ~newer;
    end

    // Saturating count of slots written since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fill <= FILL_EMPTY;
        else if (wr_en && fill != FILL_BOTH)
            fill <= (fill == FILL_EMPTY) ? FILL_ONE : FILL_BOTH;
    end

    assign older_word = slot[~newer];
    assign both_full  = (fill == FILL_BOTH);

    // R5
    ptr_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (newer != $past(newer)));

    // R6
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(both_full) |-> $past(wr_en));

    // R7
    older_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(older_word));
endmodule

// File: rtl/holdover_word_store.sv
// Top level: gates capture on lock and holdover, divides the timebase into
// update periods, and presents the older stored word for holdover use.
// Assumes locked and holdover_req are synchronous to clk.
module holdover_word_store #(
    parameter int WORD_W           = 24,
    parameter int TICKS_PER_PERIOD = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] ctrl_word,
    input  logic              locked,
    input  logic              holdover_req,
    input  logic              tick,
    output logic [WORD_W-1:0] hold_word,
    output logic              hold_valid
);
    localparam logic [WORD_W-1:0] CENTER = {1'b1, {(WORD_W-1){1'b0}}};

    logic              cap_en;
    logic              cap_stb;
    logic [WORD_W-1:0] older_word;
    logic              both_full;

    assign cap_en = locked && !holdover_req;

    hfws_period_div #(
        .TICKS_PER_PERIOD(TICKS_PER_PERIOD)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (cap_en),
        .tick   (tick),
        .cap_stb(cap_stb)
    );

    hfws_slot_bank #(
        .WORD_W   (WORD_W),
        .INIT_WORD(CENTER)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cap_stb),
        .wr_word   (ctrl_word),
        .older_word(older_word),
        .both_full (both_full)
    );

    assign hold_word  = both_full ? older_word : CENTER;
    assign hold_valid = both_full;

    // R4
    hold_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        holdover_req |=> $stable(hold_word));

    // R6
    center_until_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_valid |-> (hold_word == CENTER));
endmodule

// File: tb/holdover_word_store_tb.sv
`timescale 1ns/1ps
module holdover_word_store_tb;
    localparam int W = 16;
    localparam int P = 4;
    localparam logic [W-1:0] CENTER = 16'h8000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] ctrl_word = '0;
    logic         locked = 1'b0;
    logic         holdover_req = 1'b0;
    logic         tick = 1'b0;
    logic [W-1:0] hold_word;
    logic         hold_valid;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    holdover_word_store #(.WORD_W(W), .TICKS_PER_PERIOD(P)) u_dut (
        .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .locked(locked),
        .holdover_req(holdover_req), .tick(tick),
        .hold_word(hold_word), .hold_valid(hold_valid));

    // Scoreboard queues of expected post-edge values.
    logic [W-1:0] exp_word_q[$];
    logic         exp_valid_q[$];
    string        tag_q[$];

    // Requirement-level model state.
    int           m_cnt;
    logic [W-1:0] m_slot [2];
    int           m_newer;
    int           m_fill;

    task automatic model_reset();
        m_cnt = 0; m_slot[0] = CENTER; m_slot[1] = CENTER;
        m_newer = 1; m_fill = 0;
    endtask

    // Driver: apply one cycle of stimulus and queue the expected outputs.
    task automatic step(input bit rst, input bit lk, input bit ho, input bit tk,
                        input logic [W-1:0] w, input string tag);
        bit en;
        @(negedge clk);
        rst_n = !rst; locked = lk; holdover_req = ho; tick = tk; ctrl_word = w;
        if (rst) model_reset();
        else begin
            en = lk && !ho;
            if (!en) m_cnt = 0;
            else if (tk) begin
                if (m_cnt == P - 1) begin
                    m_cnt = 0;
                    m_slot[1 - m_newer] = w;
                    m_newer = 1 - m_newer;
                    if (m_fill < 2) m_fill++;
                end else m_cnt++;
            end
        end
        exp_word_q.push_back(m_fill == 2 ? m_slot[1 - m_newer] : CENTER);
        exp_valid_q.push_back(m_fill == 2);
        tag_q.push_back(tag);
    endtask

    // Locked ticks, each followed by gap idle cycles.
    task automatic ticks(input int n, input int gap, input logic [W-1:0] w,
                         input bit lk, input bit ho, input string tag);
        for (int i = 0; i < n; i++) begin
            step(0, lk, ho, 1, w, tag);
            for (int g = 0; g < gap; g++) step(0, lk, ho, 0, w ^ 16'h00F0, tag);
        end
    endtask

    // Monitor: compare after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_word_q.size() > 0) begin
                logic [W-1:0] ew;
                logic ev;
                string t;
                ew = exp_word_q.pop_front();
                ev = exp_valid_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (hold_word !== ew || hold_valid !== ev) begin
                    failures++;
                    $display("FAIL %s: word=%h valid=%b expected word=%h valid=%b",
                             t, hold_word, hold_valid, ew, ev);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(4 * 20000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        model_reset();
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 16'h0000, "R1 reset");
        step(0, 1, 0, 0, 16'h0101, "R1 idle");
        step(0, 1, 0, 0, 16'h0202, "R1 idle");
        // first capture 0x1111: still not valid
        ticks(P, 1, 16'h1111, 1, 0, "R6 first capture");
        // ctrl_word wanders between ticks, capture 0x3333 on last tick
        ticks(P - 1, 2, 16'h2222, 1, 0, "R8 word wander");
        ticks(1, 1, 16'h3333, 1, 0, "R5 second capture older=1111");
        // lock lost mid-period
        ticks(2, 1, 16'h9999, 0, 0, "R3 unlocked");
        ticks(P - 1, 0, 16'hAAAA, 1, 0, "R3 partial period");
        step(0, 0, 0, 0, 16'hAAAA, "R3 drop lock");
        ticks(P, 1, 16'h4444, 1, 0, "R2 R5 third capture older=3333");
        // holdover across more than a period
        ticks(P + 2, 1, 16'h5555, 1, 1, "R4 holdover frozen");
        ticks(P, 0, 16'h6666, 1, 0, "R5 fourth capture older=4444");
        ticks(P, 3, 16'h7777, 1, 0, "R7 fifth capture older=6666");
        for (int i = 0; i < 2; i++) step(0, 1, 0, 0, 16'h1234, "R7 quiet");
        step(1, 1, 0, 1, 16'h1234, "R1 reset again");
        step(0, 1, 0, 0, 16'h1234, "R1 after reset");
        repeat (3) @(posedge clk);
        #2;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule